// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated output from an 8-bit period timer. Below the timer sit two fine-count bits, so the duty value that sets the high time has 10 bits of resolution. Software programs the period, the upper 8 duty bits and the lower 2 duty bits through a small register port. The lower duty bits share the control register with the prescaler select and the enable.

The duty value written by software is only staged. The compare logic uses a separate shadow copy that software cannot write. That copy is reloaded only when a new period starts, so a write made in the middle of a period never cuts a pulse short or stretches it.

Each timer step lasts 4 × P input clocks, where P is the prescale factor (1, 4 or 16). The two fine bits step once every P clocks. They come from a free-running clock-phase counter at divide-by-1, and from the two top bits of the prescale divider otherwise. A one-clock pulse marks each period start and can serve as an interrupt flag.

Top module: `pwm_dbuf_top`

## Requirements
- R1: After reset the period register reads 8'hFF, the shadow register reads 0, and both the output and the period pulse are low.
- R2: Register map, by `bus_addr`. Address 0 is control: bits 1:0 are the prescale select, bit 2 is the enable, bits 5:4 are the lower two duty bits, and the other bits read 0. Address 1 is the period. Address 2 holds the upper eight duty bits. Address 3 is the shadow, which is read-only. Addresses 0 to 2 read back the value last written.
- R3: With period value N and prescale factor P, one PWM period lasts (N+1)·4·P clocks. `period_pulse` is high for exactly one clock at the start of each period.
- R4: With duty value D = {upper, lower}, the output is high for D·P clocks from the start of a period, then low until the next period starts.
- R5: A duty value written during a period takes effect from the next period start. Address 3 returns the upper eight bits of the duty value in use.
- R6: A duty value of 0 keeps the output low for the whole period.
- R7: A duty value of at least 4·(N+1) keeps the output high for the whole period.
- R8: Prescale select 00 gives P=1, 01 gives P=4, and 10 or 11 gives P=16.
- R9: While the enable is 0, the output is low, no period pulses occur, the timer holds its value and the prescaler is cleared. Register contents are kept. Once enabled again, the block resumes producing correct periods.
- R10: A write to address 3 has no effect on any register or on the output.
- R11: The output rises only in the clock in which `period_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 2 | Register address, used for both reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | PWM output |
| period_pulse | output | 1 | One-clock pulse at each period start |

## Verification
A scoreboard measures the high time and the length of each complete period at the pins, and compares both with values computed from N, D and P.

The main function is tried with several input patterns:
- Mid-range duty values with non-zero lower bits show whether the fine bits take part in the compare.
- Duty values of 0, 4·(N+1)−1 and 4·(N+1) separate the always-low case, the last-clock-low case and the never-cleared case.
- Every prescale encoding, run with the same small period, separates the factors 1, 4 and 16 and the aliasing of select 11 onto 16.

Further sequences cover the rest. Duty writes made in the middle of a period, with shadow reads around them, show the buffering. A write to the shadow address shows that it is ignored. A disable and re-enable sequence shows that the output is held low and that the block then resumes.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_PERIOD = 2'd1,
        REG_DUTY   = 2'd2,
        REG_SHADOW = 2'd3
    } reg_addr_e;

    // control register field positions
    localparam int CTL_SEL_LSB = 0;
    localparam int CTL_EN_BIT  = 2;
    localparam int CTL_LO_LSB  = 4;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_dbuf_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2,
    parameter int SEL_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [TMR_W-1:0]          bus_wdata,
    output logic [TMR_W-1:0]          bus_rdata,
    input  logic [TMR_W-1:0]          shadow_hi,
    output logic [TMR_W-1:0]          period,
    output logic [TMR_W+FINE_W-1:0]   duty_stage,
    output logic [SEL_W-1:0]          psel,
    output logic                      en
);

    typedef struct packed {
        logic [TMR_W-1:0]  period;
        logic [TMR_W-1:0]  duty_hi;
        logic [FINE_W-1:0] duty_lo;
        logic [SEL_W-1:0]  psel;
        logic              en;
    } reg_state_t;

    reg_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            unique case (bus_addr)
                REG_CTRL: begin
                    st_d.psel    = bus_wdata[CTL_SEL_LSB +: SEL_W];
                    st_d.en      = bus_wdata[CTL_EN_BIT];
                    st_d.duty_lo = bus_wdata[CTL_LO_LSB +: FINE_W];
                end
                REG_PERIOD: st_d.period  = bus_wdata;
                REG_DUTY:   st_d.duty_hi = bus_wdata;
                default: ;  // shadow address: read-only
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.period <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            REG_CTRL: begin
                bus_rdata[CTL_SEL_LSB +: SEL_W]  = st_q.psel;
                bus_rdata[CTL_EN_BIT]            = st_q.en;
                bus_rdata[CTL_LO_LSB +: FINE_W]  = st_q.duty_lo;
            end
            REG_PERIOD: bus_rdata = st_q.period;
            REG_DUTY:   bus_rdata = st_q.duty_hi;
            default:    bus_rdata = shadow_hi;
        endcase
    end

    assign period     = st_q.period;
    assign duty_stage = {st_q.duty_hi, st_q.duty_lo};
    assign psel       = st_q.psel;
    assign en         = st_q.en;

    assert_shadow_wr_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_SHADOW) |=> ($stable(period) && $stable(duty_stage)
                                                && $stable(psel) && $stable(en)));

endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int FINE_W = 2,
    parameter int LEVELS = 3,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [SEL_W-1:0]  psel,
    output logic              step,
    output logic [FINE_W-1:0] fine_nx
);

    localparam int DIV_W = FINE_W * LEVELS;
    localparam logic [SEL_W-1:0] LAST_LVL = SEL_W'(LEVELS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_state_t;

    pre_state_t st_q, st_d;

    logic [SEL_W-1:0]  lvl;
    logic [DIV_W-1:0]  lim_tab  [LEVELS];
    logic [FINE_W-1:0] fine_tab [LEVELS];

    // level g: one timer step every 2^(FINE_W*(g+1)) clocks,
    // fine count is the top FINE_W bits of the active divider window
    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        assign lim_tab[g]  = DIV_W'((64'd1 << (FINE_W * (g + 1))) - 64'd1);
        assign fine_tab[g] = st_d.div[FINE_W*g +: FINE_W];
    end

    always_comb begin
        lvl  = (psel > LAST_LVL) ? LAST_LVL : psel;
        st_d = st_q;
        step = 1'b0;
        if (!en) begin
            st_d.div = '0;
        end else if (st_q.div >= lim_tab[lvl]) begin
            st_d.div = '0;
            step     = 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    assign fine_nx = fine_tab[lvl];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_div_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.div == '0));

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     step,
    input  logic [FINE_W-1:0]        fine_nx,
    input  logic [TMR_W-1:0]         period,
    input  logic [TMR_W+FINE_W-1:0]  duty_stage,
    output logic [TMR_W-1:0]         shadow_hi,
    output logic                     pwm_out,
    output logic                     period_pulse
);

    localparam int DUTY_W = TMR_W + FINE_W;

    typedef struct packed {
        logic [TMR_W-1:0]  tmr;
        logic [DUTY_W-1:0] shadow;
        logic              out;
        logic              tick;
    } core_state_t;

    core_state_t st_q, st_d;
    logic        reload;

    always_comb begin
        st_d      = st_q;
        reload    = en && step && (st_q.tmr == period);
        st_d.tick = reload;
        if (!en) begin
            st_d.out = 1'b0;
        end else begin
            if (reload) begin
                st_d.tmr    = '0;
                st_d.shadow = duty_stage;
                st_d.out    = 1'b1;
            end else if (step) begin
                st_d.tmr = st_q.tmr + 1'b1;
            end
            // clear wins over a same-cycle restart (zero duty)
            if ({st_d.tmr, fine_nx} == st_d.shadow) st_d.out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow_hi    = st_q.shadow[DUTY_W-1 -: TMR_W];
    assign pwm_out      = st_q.out;
    assign period_pulse = st_q.tick;

    assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        period_pulse |=> !period_pulse);

    assert_low_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwm_out && !period_pulse));

    assert_rise_at_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> period_pulse);

    assert_shadow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !period_pulse |-> $stable(st_q.shadow));

    assert_zero_duty_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (period_pulse && st_q.shadow == '0) |-> !pwm_out);

endmodule

// File: rtl/pwm_dbuf_top.sv
module pwm_dbuf_top
    import pwm_dbuf_pkg::*;
#(
    parameter int TMR_W  = 8,
    parameter int FINE_W = 2,
    parameter int LEVELS = 3,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [TMR_W-1:0]  bus_wdata,
    output logic [TMR_W-1:0]  bus_rdata,
    output logic              pwm_out,
    output logic              period_pulse
);

    localparam int DUTY_W = TMR_W + FINE_W;

    logic [TMR_W-1:0]  period_w;
    logic [DUTY_W-1:0] duty_stage_w;
    logic [SEL_W-1:0]  psel_w;
    logic              en_w;
    logic              step_w;
    logic [FINE_W-1:0] fine_w;
    logic [TMR_W-1:0]  shadow_hi_w;

    pwm_regs #(.TMR_W(TMR_W), .FINE_W(FINE_W), .SEL_W(SEL_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .shadow_hi  (shadow_hi_w),
        .period     (period_w),
        .duty_stage (duty_stage_w),
        .psel       (psel_w),
        .en         (en_w)
    );

    pwm_prescale #(.FINE_W(FINE_W), .LEVELS(LEVELS), .SEL_W(SEL_W)) i_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_w),
        .psel    (psel_w),
        .step    (step_w),
        .fine_nx (fine_w)
    );

    pwm_core #(.TMR_W(TMR_W), .FINE_W(FINE_W)) i_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en_w),
        .step         (step_w),
        .fine_nx      (fine_w),
        .period       (period_w),
        .duty_stage   (duty_stage_w),
        .shadow_hi    (shadow_hi_w),
        .pwm_out      (pwm_out),
        .period_pulse (period_pulse)
    );

endmodule

// File: tb/test_pwm_dbuf_top.sv
module test_pwm_dbuf_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       pwm_out;
    logic       period_pulse;

    pwm_dbuf_top i_pwm_dbuf_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .pwm_out      (pwm_out),
        .period_pulse (period_pulse)
    );

    always #10 clk = ~clk;  // 50 MHz

    typedef struct {
        bit    skip;
        int    hi;
        int    len;
        string req;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    int    prev_d = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pfac(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
    endfunction

    task automatic push_exp(input int pr, input int d, input int sel, input string req);
        item_t it;
        it.skip = 0;
        it.len  = (pr + 1) * 4 * pfac(sel);
        it.hi   = d * pfac(sel);
        if (it.hi > it.len) it.hi = it.len;
        it.req  = req;
        q.push_back(it);
    endtask

    task automatic push_skip();
        item_t it;
        it.skip = 1; it.hi = 0; it.len = 0; it.req = "";
        q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] ctrl_byte(input int d, input bit en, input int sel);
        return {2'b00, 2'(d), 1'b0, en, 2'(sel)};
    endfunction

    task automatic wait_tick();
        do @(negedge clk); while (!period_pulse);
    endtask

    // called at the negedge where a period start was seen
    task automatic apply_case(input int pr, input int d, input int sel, input int n, input string req);
        logic [7:0] r;
        push_skip();
        wr(2'd1, 8'(pr));
        wr(2'd2, 8'(d >> 2));
        wr(2'd0, ctrl_byte(d, 1'b1, sel));
        rd(2'd3, r);
        check(r == 8'(prev_d >> 2), "R5 shadow keeps active duty", r, prev_d >> 2);
        for (int i = 0; i < n; i++) push_exp(pr, d, sel, req);
        for (int i = 0; i < n + 1; i++) wait_tick();
        rd(2'd3, r);
        check(r == 8'(d >> 2), "R5 shadow after period start", r, d >> 2);
        prev_d = d;
    endtask

    // scoreboard monitor
    initial begin : monitor
        bit open = 0;
        int hi = 0;
        int len = 0;
        item_t it;
        forever begin
            @(negedge clk);
            if (rst_n && period_pulse) begin
                if (open && q.size() > 0) begin
                    it = q.pop_front();
                    if (!it.skip) begin
                        check(hi == it.hi, {it.req, " high time"}, hi, it.hi);
                        check(len == it.len, {"R3 period length (", it.req, ")"}, len, it.len);
                    end
                end
                open = 1; hi = 0; len = 0;
            end
            if (open) begin
                len++;
                if (pwm_out) hi++;
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        logic [7:0] r;
        int bad;
        repeat (5) @(negedge clk);
        // R1 reset state
        rd(2'd1, r); check(r == 8'hFF, "R1 period reset", r, 255);
        rd(2'd3, r); check(r == 8'h00, "R1 shadow reset", r, 0);
        check(pwm_out == 1'b0, "R1 output reset", pwm_out, 0);
        check(period_pulse == 1'b0, "R1 pulse reset", period_pulse, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 register map while disabled: N=9, D=21, P=1
        wr(2'd1, 8'd9);
        wr(2'd2, 8'd5);
        wr(2'd0, ctrl_byte(21, 1'b0, 0));
        rd(2'd0, r); check(r == 8'h10, "R2 control readback", r, 16);
        rd(2'd2, r); check(r == 8'd5, "R2 duty readback", r, 5);
        rd(2'd1, r); check(r == 8'd9, "R2 period readback", r, 9);
        push_exp(9, 21, 0, "R4");
        push_exp(9, 21, 0, "R4");
        wr(2'd0, ctrl_byte(21, 1'b1, 0));
        for (int i = 0; i < 3; i++) wait_tick();
        prev_d = 21;

        apply_case(9, 0, 0, 2, "R6");
        apply_case(9, 40, 0, 2, "R7");
        apply_case(9, 39, 0, 1, "R4");
        apply_case(3, 5, 1, 2, "R8");
        apply_case(2, 7, 3, 1, "R8");
        apply_case(2, 7, 2, 1, "R8");
        apply_case(4, 9, 0, 1, "R3");

        // R10 write to shadow address ignored
        wr(2'd3, 8'hAA);
        rd(2'd3, r); check(r == 8'd2, "R10 shadow write ignored", r, 2);
        rd(2'd2, r); check(r == 8'd2, "R10 duty untouched", r, 2);
        push_exp(4, 9, 0, "R10");
        wait_tick();
        rd(2'd3, r); check(r == 8'd2, "R10 shadow after period", r, 2);

        // R9 disable and resume
        push_skip();
        wr(2'd0, ctrl_byte(9, 1'b0, 0));
        bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (pwm_out || period_pulse) bad++;
        end
        check(bad == 0, "R9 quiet while disabled", bad, 0);
        rd(2'd1, r); check(r == 8'd4, "R9 period kept", r, 4);
        rd(2'd0, r); check(r == 8'h10, "R9 control kept", r, 16);
        push_exp(4, 9, 0, "R9");
        wr(2'd0, ctrl_byte(9, 1'b1, 0));
        wait_tick();
        wait_tick();
        repeat (2) @(negedge clk);
        check(q.size() == 0, "R3 scoreboard drained", q.size(), 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule